// File: doc/BRIEF.md
# Frame-Paced Gain Update Filter

This block sits downstream of an automatic gain calculator in an image sensor pipeline. The calculator offers a target gain on a valid/ready stream whenever it has one. The block keeps the most recent target and decides once per frame whether to move the active gain towards it, and by how much. Two things shape that decision. The first is a throttle that leaves a programmable number of frames untouched after each write. The second is an optional smoothing rule. When the target lies far from the current gain, the gain jumps straight to the target. Otherwise it steps towards the target by a fixed fraction of the target's value.

The target stream never back-pressures. `tgt_ready_o` is high in every cycle, including during reset. A beat is taken whenever `tgt_valid_i` is high, and a newer beat replaces any target that has not yet been used. A target that has been used once is spent: no further update happens until a new beat arrives. Configuration pins are sampled into shadow registers on each frame strobe. The update decision is made on the clock edge after the strobe and uses those shadowed values, so configuration changes made in mid-frame wait for the next strobe.

Top module: `gain_update_filter`

## Requirements
- R1: After reset `gain_o` equals GAIN_INIT (16 by default) and `tgt_ready_o` is 1.
- R2: In filter mode 0, and in the reserved mode 3, an update writes the target directly as the new gain.
- R3: In modes 1 and 2, if |target − gain| is greater than floor(gain/4), an update writes the target.
- R4: In mode 1, if |target − gain| is at most floor(gain/4), the gain moves towards the target by floor(target/2) and stops at the target.
- R5: In mode 2, under the same condition as R4, the gain moves towards the target by floor(target/4) and stops at the target.
- R6: Targets above GAIN_MAX (64 by default) are first limited to GAIN_MAX, so `gain_o` never exceeds GAIN_MAX.
- R7: With skip value N, once an update has happened the next N frames bring no update. The first frame after those N frames that holds a target updates the gain.
- R8: A frame with no unspent target leaves `gain_o` unchanged.
- R9: While the shadowed enable is 0, `gain_o` does not change. A held target stays held and is applied on the first enabled frame.
- R10: Mode, skip and enable are captured only at a frame strobe. A change made after the strobe has no effect on that frame's decision.
- R11: `gain_o` takes its new value on the second rising edge at or after the strobe edge. It never changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | One-cycle frame boundary strobe |
| tgt_valid_i | input | 1 | Calculated gain beat is valid |
| tgt_ready_o | output | 1 | Always 1; the block never stalls the calculator |
| tgt_gain_i | input | GAIN_W | Calculated target gain |
| cfg_skip_i | input | SKIP_W | Frames left alone after each update |
| cfg_mode_i | input | 2 | Filter mode: 0 direct, 1 half step, 2 quarter step, 3 as 0 |
| cfg_en_i | input | 1 | Automatic gain enable |
| gain_o | output | GAIN_W | Active gain |

## Verification
A wrong internal state shows at `gain_o` in the cycle after the next frame decision. A stale or uncleared target flag makes the gain move in a frame that should be quiet. A skip counter that is off by one moves the update one frame early or late. The value of each step shows up as a wrong gain value, and the cases on either side of the quarter threshold and at the saturation limit tell the jump and step rules apart. The shadow registers can only be seen through configuration changes made between a strobe and its decision edge, so the bench drives exactly that.

// File: rtl/gain_filter_pkg.sv
package gain_filter_pkg;
  typedef enum logic [1:0] {
    FLT_DIRECT  = 2'd0,
    FLT_HALF    = 2'd1,
    FLT_QUARTER = 2'd2,
    FLT_RSVD    = 2'd3
  } flt_mode_e;
endpackage

// File: rtl/gain_frame_ctrl.sv
module gain_frame_ctrl
  import gain_filter_pkg::*;
#(
  parameter int GAIN_W = 7,
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              tgt_valid_i,
  input  logic [GAIN_W-1:0] tgt_gain_i,
  input  logic [SKIP_W-1:0] cfg_skip_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_en_i,
  output logic              upd_o,
  output logic [GAIN_W-1:0] tgt_q_o,
  output flt_mode_e         mode_o,
  output logic              en_o
);
  localparam logic [SKIP_W-1:0] CNT_TOP = {SKIP_W{1'b1}};

  logic [SKIP_W-1:0] skip_q, cnt_q;
  flt_mode_e         mode_q;
  logic              en_q, decide_q, have_q;
  logic [GAIN_W-1:0] tgt_q;
  logic              decide_on;

  // shadow registers: loaded only on the frame strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q   <= '0;
      mode_q   <= FLT_DIRECT;
      en_q     <= 1'b0;
      decide_q <= 1'b0;
    end else begin
      decide_q <= frame_start_i;
      if (frame_start_i) begin
        skip_q <= cfg_skip_i;
        mode_q <= flt_mode_e'(cfg_mode_i);
        en_q   <= cfg_en_i;
      end
    end
  end

  assign decide_on = decide_q && en_q;
  assign upd_o     = decide_on && have_q && (cnt_q >= skip_q);

  // target holding: newest beat wins, a used target is spent
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      have_q <= 1'b0;
    end else begin
      if (tgt_valid_i) begin
        tgt_q  <= tgt_gain_i;
        have_q <= 1'b1;
      end else if (upd_o) begin
        have_q <= 1'b0;
      end
    end
  end

  // frames since last update, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (decide_on) begin
      if (upd_o)                cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tgt_q_o = tgt_q;
  assign mode_o  = mode_q;
  assign en_o    = en_q;
endmodule

// File: rtl/gain_step_filter.sv
module gain_step_filter
  import gain_filter_pkg::*;
#(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 64
) (
  input  flt_mode_e         mode_i,
  input  logic [GAIN_W-1:0] cur_i,
  input  logic [GAIN_W-1:0] tgt_i,
  output logic [GAIN_W-1:0] nxt_o
);
  localparam int EW = GAIN_W + 2;
  localparam logic [EW-1:0] LIMIT = EW'(GAIN_MAX);

  logic [EW-1:0] t, c, diff, thr, step, up_v, dn_v, res;
  logic          rising;

  always_comb begin
    t = EW'(tgt_i);
    if (t > LIMIT) t = LIMIT;
    c      = EW'(cur_i);
    rising = (t >= c);
    diff   = rising ? (t - c) : (c - t);
    thr    = c >> 2;
    step   = (mode_i == FLT_HALF) ? (t >> 1) : (t >> 2);
    up_v   = c + step;
    if (up_v > t) up_v = t;
    dn_v   = (c > step) ? (c - step) : '0;
    if (dn_v < t) dn_v = t;

    unique case (mode_i)
      FLT_HALF, FLT_QUARTER: begin
        if (diff > thr) res = t;
        else            res = rising ? up_v : dn_v;
      end
      default: res = t;
    endcase
    nxt_o = res[GAIN_W-1:0];
  end
endmodule

// File: rtl/gain_update_filter.sv
module gain_update_filter
  import gain_filter_pkg::*;
#(
  parameter int GAIN_W    = 7,
  parameter int GAIN_MAX  = 64,
  parameter int GAIN_INIT = 16,
  parameter int SKIP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              tgt_valid_i,
  output logic              tgt_ready_o,
  input  logic [GAIN_W-1:0] tgt_gain_i,
  input  logic [SKIP_W-1:0] cfg_skip_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_en_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic              upd_w, en_w;
  logic [GAIN_W-1:0] tgt_q_w, nxt_w, gain_q;
  flt_mode_e         mode_w;

  gain_frame_ctrl #(.GAIN_W(GAIN_W), .SKIP_W(SKIP_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .tgt_valid_i  (tgt_valid_i),
    .tgt_gain_i   (tgt_gain_i),
    .cfg_skip_i   (cfg_skip_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_en_i     (cfg_en_i),
    .upd_o        (upd_w),
    .tgt_q_o      (tgt_q_w),
    .mode_o       (mode_w),
    .en_o         (en_w)
  );

  gain_step_filter #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) step_i (
    .mode_i(mode_w),
    .cur_i (gain_q),
    .tgt_i (tgt_q_w),
    .nxt_o (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     gain_q <= GAIN_W'(GAIN_INIT);
    else if (upd_w) gain_q <= nxt_w;
  end

  assign gain_o      = gain_q;
  assign tgt_ready_o = 1'b1;
endmodule

// File: rtl/gain_update_filter_chk.sv
module gain_update_filter_chk #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start_i,
  input logic              upd,
  input logic [GAIN_W-1:0] tgt_q,
  input logic [1:0]        mode_q,
  input logic              en_q,
  input logic [GAIN_W-1:0] gain_o
);
  localparam int EW = GAIN_W + 2;
  logic [EW-1:0] lim, lo, hi;

  always_comb begin
    lim = EW'(tgt_q);
    if (lim > EW'(GAIN_MAX)) lim = EW'(GAIN_MAX);
    lo = (lim < EW'(gain_o)) ? lim : EW'(gain_o);
    hi = (lim < EW'(gain_o)) ? EW'(gain_o) : lim;
  end

  AST_GAIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    EW'(gain_o) <= EW'(GAIN_MAX)); // R6
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (mode_q == 2'd0 || mode_q == 2'd3)) |=> (EW'(gain_o) == $past(lim))); // R2
  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((EW'(gain_o) >= $past(lo)) && (EW'(gain_o) <= $past(hi)))); // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |=> $stable(gain_o)); // R9
  AST_QUIET_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start_i, 2)) |-> $stable(gain_o)); // R11
endmodule

bind gain_update_filter gain_update_filter_chk #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start_i(frame_start_i),
  .upd          (upd_w),
  .tgt_q        (tgt_q_w),
  .mode_q       (mode_w),
  .en_q         (en_w),
  .gain_o       (gain_o)
);

// File: tb/gain_update_filter_tb.sv
module gain_update_filter_tb_top;
  localparam int GW = 7;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          tgt_valid_i = 1'b0;
  logic          tgt_ready_o;
  logic [GW-1:0] tgt_gain_i = '0;
  logic [SW-1:0] cfg_skip_i = '0;
  logic [1:0]    cfg_mode_i = 2'd0;
  logic          cfg_en_i = 1'b1;
  logic [GW-1:0] gain_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gain_update_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
    .tgt_valid_i(tgt_valid_i), .tgt_ready_o(tgt_ready_o), .tgt_gain_i(tgt_gain_i),
    .cfg_skip_i(cfg_skip_i), .cfg_mode_i(cfg_mode_i), .cfg_en_i(cfg_en_i),
    .gain_o(gain_o)
  );

  // {mode, target, expected gain}, each row one frame from the previous row's gain
  localparam logic [15:0] VEC [0:11] = '{
    {2'd0, 7'd40,  7'd40},  // R2 direct from 16
    {2'd2, 7'd30,  7'd33},  // R5 partial quarter step down
    {2'd2, 7'd30,  7'd30},  // R5 step stops at target
    {2'd1, 7'd36,  7'd36},  // R4 half step stops at target
    {2'd1, 7'd50,  7'd50},  // R3 jump, diff 14 > 9
    {2'd3, 7'd20,  7'd20},  // R2 reserved mode acts direct
    {2'd0, 7'd100, 7'd64},  // R6 limited to max
    {2'd2, 7'd50,  7'd52},  // R5 diff 14 within 16
    {2'd2, 7'd0,   7'd0},   // R3 jump to zero
    {2'd2, 7'd0,   7'd0},   // R5 zero step at zero
    {2'd2, 7'd3,   7'd3},   // R3 threshold 0 at zero gain
    {2'd1, 7'd127, 7'd64}   // R6 limit then jump
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_target(input int v);
    @(negedge clk);
    tgt_valid_i = 1'b1;
    tgt_gain_i  = GW'(v);
    @(negedge clk);
    tgt_valid_i = 1'b0;
  endtask

  // strobe, then wait past the decision edge
  task automatic run_frame();
    @(negedge clk);
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gain after reset", gain_o, 16);
    check("R1 ready", tgt_ready_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gain held out of reset", gain_o, 16);

    for (int i = 0; i < 12; i++) begin
      cfg_mode_i = VEC[i][15:14];
      send_target(int'(VEC[i][13:7]));
      run_frame();
      check($sformatf("R2-table row %0d", i), gain_o, int'(VEC[i][6:0]));
    end

    // R7: skip two frames after the last update
    cfg_mode_i = 2'd0;
    cfg_skip_i = 4'd2;
    send_target(10);
    run_frame();
    check("R7 first skipped frame", gain_o, 64);
    run_frame();
    check("R7 second skipped frame", gain_o, 64);
    run_frame();
    check("R7 update after skip", gain_o, 10);

    // R8: no new target
    cfg_skip_i = 4'd0;
    run_frame();
    check("R8 spent target ignored", gain_o, 10);

    // R9: disabled keeps gain, held target applied later
    cfg_en_i = 1'b0;
    send_target(30);
    run_frame();
    check("R9 disabled hold", gain_o, 10);
    cfg_en_i = 1'b1;
    run_frame();
    check("R9 held target applied", gain_o, 30);

    // R10 / R11: mode changed after strobe is not used
    send_target(60);
    run_frame();
    check("R2 direct to 60", gain_o, 60);
    send_target(46);
    @(negedge clk);
    cfg_mode_i    = 2'd0;
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    cfg_mode_i    = 2'd2;
    check("R11 unchanged one cycle after strobe", gain_o, 60);
    @(negedge clk);
    check("R10 mid-frame mode change ignored", gain_o, 46);
    send_target(36);
    run_frame();
    check("R10 new mode used next frame", gain_o, 37);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule